// File: doc/BRIEF.md
# Extended capability list walker

This block searches and extends a singly linked list of extended capability headers that sits in a configuration RAM of up to 4 KB. The RAM is addressed in 32-bit words. The list always begins at byte offset 0x100. Each header word carries a 16-bit capability ID in bits 15:0, a 4-bit version in bits 19:16, and a 12-bit byte offset of the next header in bits 31:20. A next offset of zero ends the list.

A find request walks the list one RAM read at a time and keeps track of the previous entry. It returns the offset of the first header whose ID matches. If no header matches, it returns offset zero together with the offset of the tail. An append request places a new header at a given offset. When that offset is not 0x100, the block first walks to the tail with ID matching switched off. It then rewrites only the tail's next field, writes the new header, and initialises the three mask RAMs over the new region, one word per cycle.

Control is a start/busy/done handshake. The configuration RAM is single-ported with a one-cycle read latency. The three mask RAMs share one write port.

Top module: `ext_cap_walker`

## Requirements
- R1: During and after reset, busy, done, err, foundOff and prevOff are 0, and no RAM read, RAM write or mask write is issued.
- R2: If the word at 0x100 is zero, a find ends with foundOff = 0, prevOff = 0 and err = 0.
- R3: A find returns the offset of the first header in list order whose bits 15:0 equal capId, and the offset of the entry before it in prevOff (0 when the match is the header at 0x100).
- R4: A find that reaches a header with next field zero and no match returns foundOff = 0 and prevOff = the offset of that last header.
- R5: A next offset below 0x100 or above CFG_BYTES-8 (0xFF8) raises err and is never read. 0xFF8 itself is followed.
- R6: A walk that has read MAX_STEPS (1024) headers without terminating raises err.
- R7: Header layout is ID in bits 15:0, version in bits 19:16 and next byte offset in bits 31:20. Only bits 15:0 take part in matching.
- R8: An append at an offset other than 0x100 walks to the tail with matching disabled, then rewrites the tail's bits 31:20 with the new offset and keeps its bits 19:0. On an empty list it raises err and writes nothing.
- R9: The new header word is {12'h000, capVer, capId}. An append at exactly 0x100 writes it with no walk and no link.
- R10: An append needs an offset ≥ 0x100, a size ≥ 8, offset+size ≤ 4096, and both the offset and the size a multiple of 4. Otherwise err is raised and no RAM or mask word is written.
- R11: Each word of the appended region gets write-enable mask 0, write-1-to-clear mask 0 and compare mask all ones, written exactly once. No mask word outside the region changes.
- R12: start is taken only when idle. busy stays high while the operation runs. done is a one-cycle pulse with busy low. A start raised while busy is ignored, and the results hold until the next accepted start.
- R13: The configuration RAM never sees a read and a write in the same cycle. Read data is used in the cycle after the read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| opAppend | input | 1 | 0 = find, 1 = append |
| capId | input | 16 | Capability ID to find or to append |
| capVer | input | 4 | Version for the appended header |
| appendOff | input | 12 | Byte offset of the appended header |
| appendSize | input | 13 | Byte size of the appended region |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operation failed |
| foundOff | output | 12 | Matching header offset, 0 if none |
| prevOff | output | 12 | Offset of the entry before the match, or the tail |
| cfgAddr | output | 10 | Configuration RAM word address |
| cfgRdEn | output | 1 | Configuration RAM read enable |
| cfgWrEn | output | 1 | Configuration RAM write enable |
| cfgWdata | output | 32 | Configuration RAM write data |
| cfgRdata | input | 32 | Configuration RAM read data, one cycle after cfgRdEn |
| maskAddr | output | 10 | Mask RAM word address |
| maskWrEn | output | 1 | Mask RAM write enable (all three masks) |
| wmaskData | output | 32 | Write-enable mask data |
| w1cData | output | 32 | Write-1-to-clear mask data |
| cmaskData | output | 32 | Compare mask data |

## Verification
Two things can meet in the same cycle: a fresh start request and an operation that is still walking the list. The bench raises a second start, an append at 0x100 with a different ID, two cycles into a long find. It then judges the outcome at the ports. The find results must belong to the first request, and the RAM and mask contents must show none of the writes the intruding append would have made. Random lists with duplicate IDs, out-of-range links, a self loop and edge-sized append regions are compared with a bench model of the walk.

// File: rtl/ecw_pkg.sv
package ecw_pkg;
  // header word layout
  localparam int OFF_W    = 12;
  localparam int ID_W     = 16;
  localparam int VER_W    = 4;
  localparam int VER_LSB  = 16;
  localparam int NEXT_LSB = 20;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_EVAL, S_LINK, S_HDR, S_MASK, S_DONE
  } state_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;
    logic rdIssue;
    logic evalHdr;
    logic step;
    logic resFound;
    logic resTail;
    logic setErr;
    logic wrLink;
    logic wrHdr;
    logic maskWr;
  } strobe_t;

  // datapath -> control conditions
  typedef struct packed {
    logic reqOk;
    logic reqAtBase;
    logic atRoot;
    logic hdrZero;
    logic idHit;
    logic nextZero;
    logic nextBad;
    logic stepsOut;
    logic maskLast;
    logic isAppend;
  } status_t;
endpackage

// File: rtl/ecw_ctrl.sv
module ecw_ctrl
  import ecw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    opAppend,
  input  status_t stat,
  output strobe_t strb,
  output logic    busy,
  output logic    done
);
  state_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    strb = '0;
    nxt  = state;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          if (!opAppend) begin
            nxt = S_ISSUE;
          end else if (!stat.reqOk) begin
            strb.setErr = 1'b1;
            nxt = S_DONE;
          end else if (stat.reqAtBase) begin
            nxt = S_HDR;
          end else begin
            nxt = S_ISSUE;
          end
        end
      end
      S_ISSUE: begin
        strb.rdIssue = 1'b1;
        nxt = S_EVAL;
      end
      S_EVAL: begin
        strb.evalHdr = 1'b1;
        if (stat.atRoot && stat.hdrZero) begin
          if (stat.isAppend) strb.setErr = 1'b1;
          nxt = S_DONE;
        end else if (stat.idHit) begin
          strb.resFound = 1'b1;
          nxt = S_DONE;
        end else if (stat.nextZero) begin
          strb.resTail = 1'b1;
          nxt = stat.isAppend ? S_LINK : S_DONE;
        end else if (stat.nextBad || stat.stepsOut) begin
          strb.setErr = 1'b1;
          nxt = S_DONE;
        end else begin
          strb.step = 1'b1;
          nxt = S_ISSUE;
        end
      end
      S_LINK: begin
        strb.wrLink = 1'b1;
        nxt = S_HDR;
      end
      S_HDR: begin
        strb.wrHdr = 1'b1;
        nxt = S_MASK;
      end
      S_MASK: begin
        strb.maskWr = 1'b1;
        if (stat.maskLast) nxt = S_DONE;
      end
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE) && (state != S_DONE);
  assign done = (state == S_DONE);

  // R12: completion is a single-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12: a start seen while idle always leaves idle
  p_start_taken_r12: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && start) |=> (state != S_IDLE));

  // R11: mask writes only follow the new header write
  p_mask_after_hdr_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_MASK) |-> ($past(state) == S_HDR || $past(state) == S_MASK));
endmodule

// File: rtl/ecw_datapath.sv
module ecw_datapath
  import ecw_pkg::*;
#(
  parameter int CFG_BYTES = 4096,
  parameter int BASE_OFF  = 256,
  parameter int MAX_STEPS = 1024
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strb,
  output status_t                       stat,
  input  logic                          opAppend,
  input  logic [ID_W-1:0]               capId,
  input  logic [VER_W-1:0]              capVer,
  input  logic [OFF_W-1:0]              appendOff,
  input  logic [OFF_W:0]                appendSize,
  output logic                          err,
  output logic [OFF_W-1:0]              foundOff,
  output logic [OFF_W-1:0]              prevOff,
  output logic [$clog2(CFG_BYTES)-3:0]  cfgAddr,
  output logic                          cfgRdEn,
  output logic                          cfgWrEn,
  output logic [31:0]                   cfgWdata,
  input  logic [31:0]                   cfgRdata,
  output logic [$clog2(CFG_BYTES)-3:0]  maskAddr,
  output logic                          maskWrEn,
  output logic [31:0]                   wmaskData,
  output logic [31:0]                   w1cData,
  output logic [31:0]                   cmaskData
);
  localparam int WA_W   = $clog2(CFG_BYTES) - 2;
  localparam int SUM_W  = OFF_W + 2;
  localparam int STEP_W = $clog2(MAX_STEPS);
  localparam logic [OFF_W-1:0]  BASE_L    = OFF_W'(BASE_OFF);
  localparam logic [OFF_W-1:0]  TOP_L     = OFF_W'(CFG_BYTES - 8);
  localparam logic [SUM_W-1:0]  LIMIT_L   = SUM_W'(CFG_BYTES);
  localparam logic [OFF_W:0]    MIN_SZ_L  = (OFF_W+1)'(8);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(MAX_STEPS - 1);

  logic [ID_W-1:0]   reqId;
  logic [VER_W-1:0]  reqVer;
  logic [OFF_W-1:0]  reqOff;
  logic [WA_W-1:0]   reqLastW;
  logic              isAppendQ;
  logic [OFF_W-1:0]  curOff, prevOffQ;
  logic [31:0]       hdrQ;
  logic [STEP_W-1:0] stepCnt;
  logic [WA_W-1:0]   maskPtr;
  logic [OFF_W-1:0]  resFoundQ, resPrevQ;
  logic              errQ;

  // request checks, evaluated on the incoming request
  logic [SUM_W-1:0]   reqSum;
  logic [SUM_W-3:0]   endWord, lastWord;
  logic [OFF_W-1:0]   nextF;

  assign reqSum   = SUM_W'(appendOff) + SUM_W'(appendSize);
  assign endWord  = reqSum[SUM_W-1:2];
  assign lastWord = endWord - 1'b1;
  assign nextF    = cfgRdata[31:NEXT_LSB];

  always_comb begin
    stat.reqOk     = (appendOff >= BASE_L) && (appendSize >= MIN_SZ_L) &&
                     (reqSum <= LIMIT_L) && (appendOff[1:0] == 2'b00) &&
                     (appendSize[1:0] == 2'b00);
    stat.reqAtBase = (appendOff == BASE_L);
    stat.atRoot    = (prevOffQ == '0);
    stat.hdrZero   = (cfgRdata == 32'h0);
    stat.idHit     = !isAppendQ && (cfgRdata[ID_W-1:0] == reqId);
    stat.nextZero  = (nextF == '0);
    stat.nextBad   = (nextF < BASE_L) || (nextF > TOP_L);
    stat.stepsOut  = (stepCnt == STEP_LAST);
    stat.maskLast  = (maskPtr == reqLastW);
    stat.isAppend  = isAppendQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqId     <= '0;
      reqVer    <= '0;
      reqOff    <= '0;
      reqLastW  <= '0;
      isAppendQ <= 1'b0;
      curOff    <= '0;
      prevOffQ  <= '0;
      hdrQ      <= '0;
      stepCnt   <= '0;
      maskPtr   <= '0;
      resFoundQ <= '0;
      resPrevQ  <= '0;
      errQ      <= 1'b0;
    end else begin
      if (strb.load) begin
        reqId     <= capId;
        reqVer    <= capVer;
        reqOff    <= appendOff;
        reqLastW  <= lastWord[WA_W-1:0];
        isAppendQ <= opAppend;
        curOff    <= BASE_L;
        prevOffQ  <= '0;
        stepCnt   <= '0;
        maskPtr   <= appendOff[WA_W+1:2];
        resFoundQ <= '0;
        resPrevQ  <= '0;
        errQ      <= 1'b0;
      end
      if (strb.evalHdr) hdrQ <= cfgRdata;
      if (strb.step) begin
        prevOffQ <= curOff;
        curOff   <= nextF;
        stepCnt  <= stepCnt + 1'b1;
      end
      if (strb.resFound) begin
        resFoundQ <= curOff;
        resPrevQ  <= prevOffQ;
      end
      if (strb.resTail) begin
        resFoundQ <= '0;
        resPrevQ  <= curOff;
      end
      if (strb.maskWr) maskPtr <= maskPtr + 1'b1;
      if (strb.setErr) errQ <= 1'b1;
    end
  end

  // RAM and mask ports
  assign cfgAddr   = strb.wrHdr ? reqOff[WA_W+1:2] : curOff[WA_W+1:2];
  assign cfgRdEn   = strb.rdIssue;
  assign cfgWrEn   = strb.wrLink | strb.wrHdr;
  assign cfgWdata  = strb.wrLink ? {reqOff, hdrQ[NEXT_LSB-1:0]}
                                 : {{(32-NEXT_LSB){1'b0}}, reqVer, reqId};
  assign maskAddr  = maskPtr;
  assign maskWrEn  = strb.maskWr;
  assign wmaskData = 32'h0;
  assign w1cData   = 32'h0;
  assign cmaskData = 32'hFFFF_FFFF;

  assign err      = errQ;
  assign foundOff = resFoundQ;
  assign prevOff  = resPrevQ;

  // R13: single-port RAM, never read and write together
  p_single_port_r13: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgRdEn && cfgWrEn));

  // R5: every header read lies inside the legal window
  p_read_in_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdEn |-> (curOff >= BASE_L && curOff <= TOP_L));

  // R11: mask writes stay inside the appended region
  p_mask_in_region_r11: assert property (@(posedge clk) disable iff (!rstN)
    maskWrEn |-> (maskPtr >= reqOff[WA_W+1:2] && maskPtr <= reqLastW));

  // R8: only a tail header of an append is relinked
  p_link_tail_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLink |-> (hdrQ[31:NEXT_LSB] == '0 && isAppendQ));
endmodule

// File: rtl/ext_cap_walker.sv
module ext_cap_walker
  import ecw_pkg::*;
#(
  parameter int CFG_BYTES = 4096,
  parameter int BASE_OFF  = 256,
  parameter int MAX_STEPS = 1024
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic                          opAppend,
  input  logic [15:0]                   capId,
  input  logic [3:0]                    capVer,
  input  logic [11:0]                   appendOff,
  input  logic [12:0]                   appendSize,
  output logic                          busy,
  output logic                          done,
  output logic                          err,
  output logic [11:0]                   foundOff,
  output logic [11:0]                   prevOff,
  output logic [$clog2(CFG_BYTES)-3:0]  cfgAddr,
  output logic                          cfgRdEn,
  output logic                          cfgWrEn,
  output logic [31:0]                   cfgWdata,
  input  logic [31:0]                   cfgRdata,
  output logic [$clog2(CFG_BYTES)-3:0]  maskAddr,
  output logic                          maskWrEn,
  output logic [31:0]                   wmaskData,
  output logic [31:0]                   w1cData,
  output logic [31:0]                   cmaskData
);
  strobe_t strb;
  status_t stat;

  ecw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opAppend(opAppend),
    .stat(stat), .strb(strb), .busy(busy), .done(done)
  );

  ecw_datapath #(
    .CFG_BYTES(CFG_BYTES), .BASE_OFF(BASE_OFF), .MAX_STEPS(MAX_STEPS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .stat(stat),
    .opAppend(opAppend), .capId(capId), .capVer(capVer),
    .appendOff(appendOff), .appendSize(appendSize),
    .err(err), .foundOff(foundOff), .prevOff(prevOff),
    .cfgAddr(cfgAddr), .cfgRdEn(cfgRdEn), .cfgWrEn(cfgWrEn),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .maskAddr(maskAddr), .maskWrEn(maskWrEn),
    .wmaskData(wmaskData), .w1cData(w1cData), .cmaskData(cmaskData)
  );
endmodule

// File: tb/ext_cap_walker_tb.sv
`timescale 1ns/1ps
module ext_cap_walker_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        opAppend = 1'b0;
  logic [15:0] capId = '0;
  logic [3:0]  capVer = '0;
  logic [11:0] appendOff = '0;
  logic [12:0] appendSize = '0;
  logic        busy, done, err;
  logic [11:0] foundOff, prevOff;
  logic [9:0]  cfgAddr, maskAddr;
  logic        cfgRdEn, cfgWrEn, maskWrEn;
  logic [31:0] cfgWdata, wmaskData, w1cData, cmaskData;
  logic [31:0] cfgRdata = '0;

  always #4 clk = ~clk;

  ext_cap_walker u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opAppend(opAppend),
    .capId(capId), .capVer(capVer), .appendOff(appendOff),
    .appendSize(appendSize), .busy(busy), .done(done), .err(err),
    .foundOff(foundOff), .prevOff(prevOff), .cfgAddr(cfgAddr),
    .cfgRdEn(cfgRdEn), .cfgWrEn(cfgWrEn), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .maskAddr(maskAddr), .maskWrEn(maskWrEn),
    .wmaskData(wmaskData), .w1cData(w1cData), .cmaskData(cmaskData)
  );

  logic [31:0] mem [1024];
  logic [31:0] wmM [1024];
  logic [31:0] w1M [1024];
  logic [31:0] cmM [1024];
  logic [31:0] eMem [1024];
  logic [31:0] eWm [1024];
  logic [31:0] eW1 [1024];
  logic [31:0] eCm [1024];

  always @(posedge clk) begin
    if (cfgWrEn) mem[cfgAddr] <= cfgWdata;
    if (cfgRdEn) cfgRdata <= mem[cfgAddr];
    if (maskWrEn) begin
      wmM[maskAddr] <= wmaskData;
      w1M[maskAddr] <= w1cData;
      cmM[maskAddr] <= cmaskData;
    end
  end

  int nChecks = 0;
  int nErr = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // bench model of the walk over the expected RAM image
  function automatic void refWalk(input logic [15:0] id, input bit anyId,
                                  output int f, output int p, output bit e);
    int cur, prv, steps, nx;
    bit fin;
    logic [31:0] h;
    f = 0; p = 0; e = 1'b0;
    cur = 256; prv = 0; steps = 0; fin = 1'b0;
    if (eMem[64] == 32'h0) fin = 1'b1;
    while (!fin) begin
      h = eMem[cur >> 2];
      steps++;
      nx = int'(h[31:20]);
      if (anyId && h[15:0] == id) begin
        f = cur; p = prv; fin = 1'b1;
      end else if (nx == 0) begin
        f = 0; p = cur; fin = 1'b1;
      end else if (steps >= 1024 || nx < 256 || nx > 4088) begin
        e = 1'b1; fin = 1'b1;
      end else begin
        prv = cur; cur = nx;
      end
    end
  endfunction

  function automatic void refAppend(input logic [15:0] id, input logic [3:0] ver,
                                    input int off, input int sz, output bit e);
    int f, p;
    logic [31:0] off32;
    e = 1'b0;
    off32 = off;
    if (off < 256 || sz < 8 || off + sz > 4096 || off % 4 != 0 || sz % 4 != 0) begin
      e = 1'b1;
      return;
    end
    if (off != 256) begin
      if (eMem[64] == 32'h0) begin
        e = 1'b1;
        return;
      end
      refWalk(id, 1'b0, f, p, e);
      if (e) return;
      eMem[p >> 2][31:20] = off32[11:0];
    end
    eMem[off >> 2] = {12'h000, ver, id};
    for (int w = off / 4; w < (off + sz) / 4; w++) begin
      eWm[w] = 32'h0; eW1[w] = 32'h0; eCm[w] = 32'hFFFF_FFFF;
    end
  endfunction

  task automatic snapshot();
    for (int i = 0; i < 1024; i++) begin
      eMem[i] = mem[i]; eWm[i] = wmM[i]; eW1[i] = w1M[i]; eCm[i] = cmM[i];
    end
  endtask

  function automatic int ramDiff();
    int n = 0;
    for (int i = 0; i < 1024; i++) begin
      if (mem[i] != eMem[i] || wmM[i] != eWm[i] || w1M[i] != eW1[i] || cmM[i] != eCm[i])
        n++;
    end
    return n;
  endfunction

  task automatic clearMem();
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
  endtask

  // R7: header = {next[31:20], ver[19:16], id[15:0]}
  task automatic setHdr(input int off, input logic [15:0] id, input logic [3:0] ver,
                        input int nxt);
    logic [31:0] n32;
    n32 = nxt;
    mem[off >> 2] = {n32[11:0], ver, id};
  endtask

  task automatic runOp(input bit app, input logic [15:0] id, input logic [3:0] ver,
                       input int off, input int sz, input bit poke, input string req);
    int f, p, t;
    bit e;
    logic [31:0] o32, s32;
    f = 0; p = 0;
    snapshot();
    if (app) refAppend(id, ver, off, sz, e);
    else refWalk(id, 1'b1, f, p, e);
    o32 = off; s32 = sz;
    @(negedge clk);
    opAppend = app; capId = id; capVer = ver;
    appendOff = o32[11:0]; appendSize = s32[12:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      check(busy, "R12", "busy during walk", busy, 1);
      opAppend = 1'b1; capId = ~id; appendOff = 12'h100; appendSize = 13'd8; start = 1'b1;
      @(negedge clk);
      start = 1'b0; opAppend = app;
    end
    t = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check(done == 1'b1, req, "done seen", done, 1);
    check(err == e, req, "err flag", err, e);
    if (!app && !e) begin
      check(int'(foundOff) == f, req, "found offset", foundOff, f);
      check(int'(prevOff) == p, req, "previous offset", prevOff, p);
    end
    @(negedge clk);
    check(!done && !busy, "R12", "done single pulse", done, 0);
    check(ramDiff() == 0, req, "RAM and mask contents", ramDiff(), 0);
  endtask

  int lOff [8];
  logic [15:0] lId [8];
  bit used [60];

  task automatic buildList(input int n);
    int s;
    clearMem();
    for (int i = 0; i < 60; i++) used[i] = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i == 0) s = 0;
      else begin
        s = 1 + int'($urandom % 59);
        while (used[s]) s = 1 + int'($urandom % 59);
      end
      used[s] = 1'b1;
      lOff[i] = 256 + s * 64;
      lId[i] = (i > 0 && $urandom % 4 == 0) ? lId[0] : 16'($urandom);
    end
    for (int i = 0; i < n; i++)
      setHdr(lOff[i], lId[i], 4'(1 + $urandom % 15), (i == n - 1) ? 0 : lOff[i + 1]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErr++;
      $display("FAIL R12 watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    int s, n, r, sz;
    void'($urandom(32'd7713));
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 32'h0;
      wmM[i] = $urandom; w1M[i] = $urandom; cmM[i] = $urandom;
    end
    repeat (3) @(negedge clk);
    check(!busy && !done && !err, "R1", "reset flags", {busy, done, err}, 0);
    check(foundOff == 0 && prevOff == 0, "R1", "reset results", {foundOff, prevOff}, 0);
    check(!cfgRdEn && !cfgWrEn && !maskWrEn, "R1", "reset enables",
          {cfgRdEn, cfgWrEn, maskWrEn}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: empty list
    clearMem();
    runOp(1'b0, 16'h0001, 4'h0, 0, 0, 1'b0, "R2");

    // R3 / R4 / R7: three-entry list with version bits set
    clearMem();
    setHdr(256, 16'h0010, 4'h2, 512);
    setHdr(512, 16'h0020, 4'h1, 768);
    setHdr(768, 16'h0030, 4'hF, 0);
    runOp(1'b0, 16'h0010, 4'h0, 0, 0, 1'b0, "R3");
    runOp(1'b0, 16'h0030, 4'h0, 0, 0, 1'b0, "R3");
    runOp(1'b0, 16'h0099, 4'h0, 0, 0, 1'b0, "R4");
    runOp(1'b0, 16'h0002, 4'h0, 0, 0, 1'b0, "R7");
    // R12: start while busy is ignored
    runOp(1'b0, 16'h0030, 4'h0, 0, 0, 1'b1, "R12");
    // R8: append at a non-base offset links from the tail
    runOp(1'b1, 16'hBEEF, 4'h5, 1024, 32, 1'b0, "R8");
    runOp(1'b0, 16'hBEEF, 4'h0, 0, 0, 1'b0, "R8");
    // R10: bad append requests
    runOp(1'b1, 16'h1111, 4'h1, 252, 8, 1'b0, "R10");
    runOp(1'b1, 16'h1111, 4'h1, 2048, 4, 1'b0, "R10");
    runOp(1'b1, 16'h1111, 4'h1, 3840, 260, 1'b0, "R10");
    runOp(1'b1, 16'h1111, 4'h1, 2050, 8, 1'b0, "R10");
    runOp(1'b1, 16'h1111, 4'h1, 2048, 10, 1'b0, "R10");
    // R11: region ending exactly at the top of the RAM
    runOp(1'b1, 16'h2222, 4'h3, 4088, 8, 1'b0, "R11");

    // R5: links out of range, and the top legal offset
    clearMem();
    setHdr(256, 16'h0001, 4'h1, 240);
    runOp(1'b0, 16'h0005, 4'h0, 0, 0, 1'b0, "R5");
    clearMem();
    setHdr(256, 16'h0001, 4'h1, 4092);
    runOp(1'b0, 16'h0005, 4'h0, 0, 0, 1'b0, "R5");
    clearMem();
    setHdr(256, 16'h0001, 4'h1, 4088);
    setHdr(4088, 16'h0007, 4'h1, 0);
    runOp(1'b0, 16'h0007, 4'h0, 0, 0, 1'b0, "R5");

    // R6: self loop hits the step limit, for find and append
    clearMem();
    setHdr(256, 16'h0001, 4'h1, 256);
    runOp(1'b0, 16'h0002, 4'h0, 0, 0, 1'b0, "R6");
    runOp(1'b1, 16'h0002, 4'h1, 1024, 8, 1'b0, "R6");

    // R8: append to empty list away from base; R9: append at base
    clearMem();
    runOp(1'b1, 16'h3333, 4'h2, 1024, 8, 1'b0, "R8");
    runOp(1'b1, 16'h4444, 4'h6, 256, 16, 1'b0, "R9");
    runOp(1'b0, 16'h4444, 4'h0, 0, 0, 1'b0, "R9");

    // constrained random mix; R13 single-port behaviour holds throughout
    for (int it = 0; it < 50; it++) begin
      n = int'($urandom % 7);
      buildList(n);
      r = int'($urandom % 3);
      if (r == 0) begin
        runOp(1'b0, (n > 0) ? lId[int'($urandom % 32'(n))] : 16'($urandom), 4'h0, 0, 0,
              1'b0, "R3");
      end else if (r == 1) begin
        runOp(1'b0, 16'($urandom), 4'h0, 0, 0, 1'b0, "R4");
      end else begin
        s = int'($urandom % 60);
        while (used[s]) s = int'($urandom % 60);
        sz = 8 + 4 * int'($urandom % 15);
        runOp(1'b1, 16'($urandom), 4'($urandom), 256 + s * 64, sz, 1'b0, "R11");
      end
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  // R13: the RAM never sees a read and a write together
  always @(negedge clk) begin
    if (rstN && cfgRdEn && cfgWrEn) begin
      nChecks++;
      nErr++;
      $display("FAIL R13 read and write same cycle actual=1 expected=0");
    end
  end
endmodule